// File: doc/BRIEF.md
# Single-Beat AXI4-Lite Command Master

This block lets local logic issue single AXI4-Lite reads and writes through a start/complete command port. A write is launched by a one-cycle start pulse that carries an address and a data word. The block then drives the address and write-data channels and waits for the write response. It reports completion with a one-cycle done pulse, plus an error flag when the response code is not OKAY. A read is launched the same way with only an address. The returned word appears on a data output together with a one-cycle valid/done pulse. It stays on that output until the next read completes.

Reads and writes run in two separate engines, so one of each can be in flight at the same time. Each engine holds at most one transaction. The address and data are captured when a command is accepted, so the command inputs may change freely afterwards. Each handshake is retired channel by channel: a valid drops on its own ready, and the response-side ready is raised for exactly the handshake cycle. Reset is asserted asynchronously and released through a synchronizer.

Top module: `axil_cmd_master`

## Requirements
- R1: While reset is asserted, and after it is released until a command arrives, every AXI valid and ready output and every done, valid and error output is low.
- R2: A write start accepted in a cycle raises m_awvalid and m_wvalid together in the next cycle. m_awaddr and m_wdata then carry the command's address and data, m_wstrb is all ones, and m_awprot and m_arprot are zero.
- R3: m_awvalid stays high with a stable address until the cycle after an AW handshake and then drops. m_wvalid does the same on its own W handshake. Neither is high while m_bready is high.
- R4: m_bready rises in the cycle after m_bvalid is first seen high in the response phase. It stays high only until the B handshake and is low in the following cycle.
- R5: wr_done is high exactly in the B handshake cycle (m_bvalid and m_bready both high). wr_err is high in that cycle when m_bresp is not 2'b00, i.e. for EXOKAY, SLVERR or DECERR.
- R6: A read start accepted in a cycle raises m_arvalid in the next cycle with m_araddr equal to the command address. m_arvalid drops in the cycle after the AR handshake.
- R7: m_rready rises in the cycle after m_rvalid is seen after the AR handshake. It stays high only until the R handshake and is low in the following cycle.
- R8: rd_valid and rd_done are high exactly in the R handshake cycle, with rd_data equal to m_rdata. rd_data keeps that word until the next R handshake.
- R9: rd_err is high in the R handshake cycle when m_rresp is not 2'b00.
- R10: A start pulse arriving while the same-direction engine is busy (from acceptance through its handshake cycle) is ignored. Changing the command address or data after acceptance does not change the transaction.
- R11: A read and a write may be in flight at the same time without affecting each other's timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | One-cycle write command pulse |
| wr_addr | input | 32 | Write command address |
| wr_wdata | input | 32 | Write command data |
| wr_done | output | 1 | Write completion pulse |
| wr_err | output | 1 | Write response not OKAY (with wr_done) |
| rd_start | input | 1 | One-cycle read command pulse |
| rd_addr | input | 32 | Read command address |
| rd_rdata | output | 32 | Read result, held until next read completes |
| rd_valid | output | 1 | Read data valid pulse |
| rd_done | output | 1 | Read completion pulse |
| rd_err | output | 1 | Read response not OKAY (with rd_done) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | 32 | Write address |
| m_awprot | output | 3 | Write protection, zero |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write strobes, all ones |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | 32 | Read address |
| m_arprot | output | 3 | Read protection, zero |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response code |

## Verification
The in-RTL assertions check the channel rules on every cycle: valids hold with stable payload until their handshake and then drop, response-side readies rise only after the matching valid and last a single handshake, and a launch carries the captured command. Other behaviour is shown only by the bench scenarios against the slave it emulates with varied ready and response delays: AW and W accepted in either order, error codes on both responses, busy-time start pulses and post-acceptance input changes being ignored, the read result being held, and a read overlapping a write.

// File: rtl/axil_cmd_pkg.sv
package axil_cmd_pkg;
  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_XFER = 2'd1,
    WR_RESP = 2'd2,
    WR_ACK  = 2'd3
  } wr_state_e;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_ADDR = 2'd1,
    RD_WAIT = 2'd2,
    RD_ACK  = 2'd3
  } rd_state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int         PROT_W    = 3;
endpackage

// File: rtl/axil_rst_sync.sv
module axil_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  // asynchronous assertion, release after STAGES clock edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/axil_wr_engine.sv
module axil_wr_engine
  import axil_cmd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              cmd_done,
  output logic              cmd_err,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  input  logic              bvalid,
  output logic              bready,
  input  logic [1:0]        bresp
);
  wr_state_e         st_q, st_d;
  logic              awv_q, awv_d;
  logic              wv_q, wv_d;
  logic              brdy_q, brdy_d;
  logic              load_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              resp_hs;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    awv_d   = awv_q;
    wv_d    = wv_q;
    brdy_d  = brdy_q;
    load_en = 1'b0;
    case (st_q)
      WR_IDLE: begin
        if (cmd_start) begin
          load_en = 1'b1;
          awv_d   = 1'b1;
          wv_d    = 1'b1;
          st_d    = WR_XFER;
        end
      end
      WR_XFER: begin
        if (awv_q && awready) awv_d = 1'b0;
        if (wv_q && wready)   wv_d  = 1'b0;
        if (!awv_d && !wv_d)  st_d  = WR_RESP;
      end
      WR_RESP: begin
        if (bvalid) begin
          brdy_d = 1'b1;
          st_d   = WR_ACK;
        end
      end
      WR_ACK: begin
        if (bvalid) begin
          brdy_d = 1'b0;
          st_d   = WR_IDLE;
        end
      end
      default: st_d = WR_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WR_IDLE;
      awv_q  <= 1'b0;
      wv_q   <= 1'b0;
      brdy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      awv_q  <= awv_d;
      wv_q   <= wv_d;
      brdy_q <= brdy_d;
    end
  end

  // payload registers, loaded only on command acceptance
  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q <= cmd_addr;
      data_q <= cmd_data;
    end
  end

  assign resp_hs  = brdy_q & bvalid;
  assign cmd_done = resp_hs;
  assign cmd_err  = resp_hs & (bresp != RESP_OKAY);
  assign awvalid  = awv_q;
  assign wvalid   = wv_q;
  assign bready   = brdy_q;
  assign awaddr   = addr_q;
  assign wdata    = data_q;

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WR_IDLE && cmd_start) |=>
      (awvalid && wvalid && awaddr == $past(cmd_addr) && wdata == $past(cmd_data)));

  assert_aw_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr)));

  assert_aw_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && awready) |=> !awvalid);

  assert_w_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> (wvalid && $stable(wdata)));

  assert_w_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && wready) |=> !wvalid);

  assert_quiet_in_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bready |-> (!awvalid && !wvalid));

  assert_bready_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bready) |-> $past(bvalid));

  assert_bready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bready && bvalid) |=> !bready);
endmodule

// File: rtl/axil_rd_engine.sv
module axil_rd_engine
  import axil_cmd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_rdata,
  output logic              cmd_valid,
  output logic              cmd_err,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  input  logic              rvalid,
  output logic              rready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp
);
  rd_state_e         st_q, st_d;
  logic              arv_q, arv_d;
  logic              rrdy_q, rrdy_d;
  logic              load_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] hold_q;
  logic              data_hs;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    arv_d   = arv_q;
    rrdy_d  = rrdy_q;
    load_en = 1'b0;
    case (st_q)
      RD_IDLE: begin
        if (cmd_start) begin
          load_en = 1'b1;
          arv_d   = 1'b1;
          st_d    = RD_ADDR;
        end
      end
      RD_ADDR: begin
        if (arready) begin
          arv_d = 1'b0;
          st_d  = RD_WAIT;
        end
      end
      RD_WAIT: begin
        if (rvalid) begin
          rrdy_d = 1'b1;
          st_d   = RD_ACK;
        end
      end
      RD_ACK: begin
        if (rvalid) begin
          rrdy_d = 1'b0;
          st_d   = RD_IDLE;
        end
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      arv_q  <= 1'b0;
      rrdy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      arv_q  <= arv_d;
      rrdy_q <= rrdy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) addr_q <= cmd_addr;
  end

  // result register with explicit enable, cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (data_hs) hold_q <= rdata;
  end

  assign data_hs   = rrdy_q & rvalid;
  assign cmd_valid = data_hs;
  assign cmd_err   = data_hs & (rresp != RESP_OKAY);
  assign cmd_rdata = data_hs ? rdata : hold_q;
  assign arvalid   = arv_q;
  assign araddr    = addr_q;
  assign rready    = rrdy_q;

  assert_ar_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RD_IDLE && cmd_start) |=> (arvalid && araddr == $past(cmd_addr)));

  assert_ar_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready) |=> (arvalid && $stable(araddr)));

  assert_ar_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && arready) |=> !arvalid);

  assert_rready_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rready) |-> $past(rvalid));

  assert_rready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rready && rvalid) |=> !rready);

  assert_no_ar_with_rready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rready |-> !arvalid);

  assert_result_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !$past(cmd_valid)) |-> $stable(cmd_rdata));
endmodule

// File: rtl/axil_cmd_master.sv
module axil_cmd_master
  import axil_cmd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_start,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_wdata,
  output logic                wr_done,
  output logic                wr_err,
  input  logic                rd_start,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_rdata,
  output logic                rd_valid,
  output logic                rd_done,
  output logic                rd_err,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [PROT_W-1:0]   m_awprot,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [1:0]          m_bresp,
  output logic                m_arvalid,
  input  logic                m_arready,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [PROT_W-1:0]   m_arprot,
  input  logic                m_rvalid,
  output logic                m_rready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp
);
  localparam int STRB_W = DATA_W / 8;

  logic core_rst_n;
  logic rd_hs;

  axil_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  axil_wr_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cmd_start (wr_start),
    .cmd_addr  (wr_addr),
    .cmd_data  (wr_wdata),
    .cmd_done  (wr_done),
    .cmd_err   (wr_err),
    .awvalid   (m_awvalid),
    .awready   (m_awready),
    .awaddr    (m_awaddr),
    .wvalid    (m_wvalid),
    .wready    (m_wready),
    .wdata     (m_wdata),
    .bvalid    (m_bvalid),
    .bready    (m_bready),
    .bresp     (m_bresp)
  );

  axil_rd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cmd_start (rd_start),
    .cmd_addr  (rd_addr),
    .cmd_rdata (rd_rdata),
    .cmd_valid (rd_hs),
    .cmd_err   (rd_err),
    .arvalid   (m_arvalid),
    .arready   (m_arready),
    .araddr    (m_araddr),
    .rvalid    (m_rvalid),
    .rready    (m_rready),
    .rdata     (m_rdata),
    .rresp     (m_rresp)
  );

  assign rd_valid = rd_hs;
  assign rd_done  = rd_hs;
  assign m_wstrb  = {STRB_W{1'b1}};
  assign m_awprot = '0;
  assign m_arprot = '0;
endmodule

// File: tb/axil_cmd_master_tb.sv
module axil_cmd_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_start = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_wdata = '0;
  logic        wr_done, wr_err;
  logic        rd_start = 1'b0;
  logic [31:0] rd_addr = '0;
  logic [31:0] rd_rdata;
  logic        rd_valid, rd_done, rd_err;
  logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
  logic [31:0] m_awaddr, m_wdata, m_araddr;
  logic [2:0]  m_awprot, m_arprot;
  logic [3:0]  m_wstrb;
  logic        s_awready = 1'b0, s_wready = 1'b0, s_bvalid = 1'b0;
  logic        s_arready = 1'b0, s_rvalid = 1'b0;
  logic [1:0]  s_bresp = 2'b00, s_rresp = 2'b00;
  logic [31:0] s_rdata = '0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axil_cmd_master u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_start(wr_start), .wr_addr(wr_addr), .wr_wdata(wr_wdata),
    .wr_done(wr_done), .wr_err(wr_err),
    .rd_start(rd_start), .rd_addr(rd_addr), .rd_rdata(rd_rdata),
    .rd_valid(rd_valid), .rd_done(rd_done), .rd_err(rd_err),
    .m_awvalid(m_awvalid), .m_awready(s_awready), .m_awaddr(m_awaddr), .m_awprot(m_awprot),
    .m_wvalid(m_wvalid), .m_wready(s_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_bvalid(s_bvalid), .m_bready(m_bready), .m_bresp(s_bresp),
    .m_arvalid(m_arvalid), .m_arready(s_arready), .m_araddr(m_araddr), .m_arprot(m_arprot),
    .m_rvalid(s_rvalid), .m_rready(m_rready), .m_rdata(s_rdata), .m_rresp(s_rresp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // slave configuration
  int aw_dly = 0, w_dly = 0, b_dly = 0, ar_dly = 0, r_dly = 0;
  logic [1:0] b_code = 2'b00, r_code = 2'b00;
  logic [31:0] aw_log[$];
  logic [31:0] w_log[$];
  logic [31:0] ar_log[$];

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'h5A5A_1234;
  endfunction

  // reference model, advanced on each rising edge
  int          wph = 0, rph = 0;
  logic        e_aw = 0, e_w = 0, e_br = 0, e_ar = 0, e_rr = 0;
  logic [31:0] e_awaddr = '0, e_wdata = '0, e_araddr = '0, e_hold = '0;
  logic [31:0] ar_cap = '0;

  always @(posedge clk) begin
    case (wph)
      0: if (wr_start) begin e_aw = 1; e_w = 1; e_awaddr = wr_addr; e_wdata = wr_wdata; wph = 1; end
      1: begin
        if (e_aw && s_awready) e_aw = 0;
        if (e_w && s_wready)   e_w  = 0;
        if (!e_aw && !e_w)     wph  = 2;
      end
      2: if (s_bvalid) begin e_br = 1; wph = 3; end
      default: if (s_bvalid) begin e_br = 0; wph = 0; end
    endcase
    case (rph)
      0: if (rd_start) begin e_ar = 1; e_araddr = rd_addr; rph = 1; end
      1: if (s_arready) begin e_ar = 0; rph = 2; end
      2: if (s_rvalid) begin e_rr = 1; rph = 3; end
      default: if (s_rvalid) begin e_hold = s_rdata; e_rr = 0; rph = 0; end
    endcase
  end

  // per-cycle comparison, then slave update, on the falling edge
  int  aw_cnt = 0, w_cnt = 0, b_cnt = 0, ar_cnt = 0, r_cnt = 0;
  bit  aw_got = 0, w_got = 0, b_drop = 0, ar_got = 0, r_drop = 0;
  bit  cmp_en = 0;

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(m_awvalid == e_aw, "R3 awvalid", 32'(m_awvalid), 32'(e_aw));
      chk(m_wvalid == e_w, "R3 wvalid", 32'(m_wvalid), 32'(e_w));
      if (e_aw) chk(m_awaddr == e_awaddr, "R2 awaddr", m_awaddr, e_awaddr);
      if (e_w)  chk(m_wdata == e_wdata, "R2 wdata", m_wdata, e_wdata);
      chk(m_wstrb == 4'hF && m_awprot == 3'd0 && m_arprot == 3'd0, "R2 strb/prot",
          {25'd0, m_wstrb, m_awprot}, 32'h78);
      chk(m_bready == e_br, "R4 bready", 32'(m_bready), 32'(e_br));
      chk(wr_done == (e_br && s_bvalid), "R5 wr_done", 32'(wr_done), 32'(e_br && s_bvalid));
      chk(wr_err == (e_br && s_bvalid && s_bresp != 2'b00), "R5 wr_err",
          32'(wr_err), 32'(e_br && s_bvalid && s_bresp != 2'b00));
      chk(m_arvalid == e_ar, "R6 arvalid", 32'(m_arvalid), 32'(e_ar));
      if (e_ar) chk(m_araddr == e_araddr, "R6 araddr", m_araddr, e_araddr);
      chk(m_rready == e_rr, "R7 rready", 32'(m_rready), 32'(e_rr));
      chk(rd_valid == (e_rr && s_rvalid) && rd_done == rd_valid, "R8 rd_valid/done",
          {30'd0, rd_valid, rd_done}, {30'd0, e_rr && s_rvalid, e_rr && s_rvalid});
      chk(rd_rdata == ((e_rr && s_rvalid) ? s_rdata : e_hold), "R8 rd_rdata",
          rd_rdata, (e_rr && s_rvalid) ? s_rdata : e_hold);
      chk(rd_err == (e_rr && s_rvalid && s_rresp != 2'b00), "R9 rd_err",
          32'(rd_err), 32'(e_rr && s_rvalid && s_rresp != 2'b00));
    end
    // AW channel
    if (s_awready) s_awready = 0;
    else if (m_awvalid && !aw_got) begin
      if (aw_cnt >= aw_dly) begin s_awready = 1; aw_got = 1; aw_cnt = 0; aw_log.push_back(m_awaddr); end
      else aw_cnt++;
    end
    // W channel
    if (s_wready) s_wready = 0;
    else if (m_wvalid && !w_got) begin
      if (w_cnt >= w_dly) begin s_wready = 1; w_got = 1; w_cnt = 0; w_log.push_back(m_wdata); end
      else w_cnt++;
    end
    // B channel
    if (b_drop) begin s_bvalid = 0; b_drop = 0; aw_got = 0; w_got = 0; b_cnt = 0; end
    else if (s_bvalid && m_bready) b_drop = 1;
    else if (aw_got && w_got && !s_awready && !s_wready && !s_bvalid) begin
      if (b_cnt >= b_dly) begin s_bvalid = 1; s_bresp = b_code; end
      else b_cnt++;
    end
    // AR channel
    if (s_arready) s_arready = 0;
    else if (m_arvalid && !ar_got) begin
      if (ar_cnt >= ar_dly) begin s_arready = 1; ar_got = 1; ar_cnt = 0; ar_cap = m_araddr; ar_log.push_back(m_araddr); end
      else ar_cnt++;
    end
    // R channel
    if (r_drop) begin s_rvalid = 0; r_drop = 0; ar_got = 0; r_cnt = 0; end
    else if (s_rvalid && m_rready) r_drop = 1;
    else if (ar_got && !s_arready && !s_rvalid) begin
      if (r_cnt >= r_dly) begin s_rvalid = 1; s_rdata = mem_word(ar_cap); s_rresp = r_code; end
      else r_cnt++;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WDOG_LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic issue_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_addr = a; wr_wdata = d; wr_start = 1;
    @(negedge clk);
    wr_start = 0; wr_addr = ~a; wr_wdata = ~d;   // R10: later input changes must not leak
  endtask

  task automatic wait_wdone(output bit err_seen);
    err_seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (wr_done) begin err_seen = wr_err; break; end
    end
  endtask

  task automatic issue_read(input logic [31:0] a);
    @(negedge clk);
    rd_addr = a; rd_start = 1;
    @(negedge clk);
    rd_start = 0; rd_addr = ~a;
  endtask

  task automatic wait_rdone(output logic [31:0] data, output bit err_seen);
    err_seen = 0; data = '0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (rd_done) begin data = rd_rdata; err_seen = rd_err; break; end
    end
  endtask

  task automatic write_case(input logic [31:0] a, input logic [31:0] d, input bit exp_err, input string tag);
    bit e;
    int n0 = aw_log.size();
    issue_write(a, d);
    wait_wdone(e);
    chk(aw_log.size() == n0 + 1 && aw_log[n0] == a, {tag, " slave AW address"}, aw_log[aw_log.size()-1], a);
    chk(w_log.size() == n0 + 1 && w_log[n0] == d, {tag, " slave W data"}, w_log[w_log.size()-1], d);
    chk(e == exp_err, {tag, " R5 error flag"}, 32'(e), 32'(exp_err));
  endtask

  task automatic read_case(input logic [31:0] a, input bit exp_err, input string tag);
    bit e;
    logic [31:0] d;
    issue_read(a);
    wait_rdone(d, e);
    chk(ar_log[ar_log.size()-1] == a, {tag, " R6 slave AR address"}, ar_log[ar_log.size()-1], a);
    chk(d == mem_word(a), {tag, " R8 returned data"}, d, mem_word(a));
    chk(e == exp_err, {tag, " R9 error flag"}, 32'(e), 32'(exp_err));
  endtask

  initial begin
    bit e;
    logic [31:0] d;
    int n0;
    cmp_en = 1;
    repeat (4) @(negedge clk);
    // R1: outputs idle during reset
    chk({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, wr_done, rd_done, rd_valid} == 8'd0,
        "R1 idle in reset", 32'({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready}), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, wr_err, rd_err} == 7'd0,
        "R1 idle after release", 32'({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready}), 0);

    // R2 R5: zero-delay write
    write_case(32'h0000_1000, 32'hDEAD_BEEF, 0, "R2 basic");
    // R3: AW slower than W
    aw_dly = 3; w_dly = 0;
    write_case(32'h0000_2004, 32'h1234_5678, 0, "R3 aw-late");
    // R3: W slower than AW
    aw_dly = 1; w_dly = 4;
    write_case(32'h0000_3008, 32'hCAFE_F00D, 0, "R3 w-late");
    // R4 R5: delayed error response
    aw_dly = 0; w_dly = 0; b_dly = 5; b_code = 2'b10;
    write_case(32'h0000_400C, 32'h0BAD_0BAD, 1, "R4 slverr");
    b_code = 2'b01; b_dly = 0;
    write_case(32'h0000_4010, 32'h0000_0001, 1, "R5 exokay");
    b_code = 2'b00;

    // R6 R8: reads
    read_case(32'h0000_0100, 0, "R6 basic");
    ar_dly = 2; r_dly = 3; r_code = 2'b11;
    read_case(32'h0000_0200, 1, "R7 delayed decerr");
    ar_dly = 0; r_dly = 0; r_code = 2'b00;
    repeat (6) @(negedge clk);
    chk(rd_rdata == mem_word(32'h0000_0200), "R8 result held", rd_rdata, mem_word(32'h0000_0200));

    // R10: start pulses while busy are ignored
    b_dly = 8;
    n0 = aw_log.size();
    issue_write(32'h0000_5000, 32'h5555_AAAA);
    repeat (3) @(negedge clk);
    wr_addr = 32'h0000_6000; wr_wdata = 32'h6666_6666; wr_start = 1;
    @(negedge clk); wr_start = 0;
    wait_wdone(e);
    repeat (12) @(negedge clk);
    chk(aw_log.size() == n0 + 1, "R10 single write issued", aw_log.size(), n0 + 1);
    chk(aw_log[n0] == 32'h0000_5000, "R10 write address kept", aw_log[n0], 32'h0000_5000);
    chk(w_log[n0] == 32'h5555_AAAA, "R10 write data kept", w_log[n0], 32'h5555_AAAA);
    b_dly = 0;
    r_dly = 6;
    n0 = ar_log.size();
    issue_read(32'h0000_0300);
    repeat (2) @(negedge clk);
    rd_addr = 32'h0000_0400; rd_start = 1;
    @(negedge clk); rd_start = 0;
    wait_rdone(d, e);
    repeat (10) @(negedge clk);
    chk(ar_log.size() == n0 + 1, "R10 single read issued", ar_log.size(), n0 + 1);
    chk(d == mem_word(32'h0000_0300), "R10 read data from first address", d, mem_word(32'h0000_0300));
    r_dly = 0;

    // R11: overlapping read and write
    aw_dly = 2; w_dly = 1; b_dly = 3; ar_dly = 1; r_dly = 2;
    fork
      write_case(32'h0000_7000, 32'h7777_0001, 0, "R11 write leg");
      read_case(32'h0000_0500, 0, "R11 read leg");
    join
    repeat (5) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule